// File: doc/BRIEF.md
# Masked Feature Register Updater

This block changes selected bits of one feature register in a serial NAND flash device. It takes a register address, a bit mask and a value. It reads the register's current contents from the device and replaces only the masked bits with the matching bits of the new value. It then writes the register back, but only when the result differs from what the device already holds. Every bus transaction goes to a command sequencer as a descriptor. The sequencer returns one response for each descriptor it accepted.

The configuration register is the one software changes most often. Its bits turn on one-time-programmable area access, on-die error correction and four-line transfers. The block keeps a local copy of this register, so an update that finds a valid copy skips the read, and an update that changes nothing issues no transaction at all. A separate single-cycle request clears every block-protection bit by writing zero to the block-lock register.

Top module: `feat_reg_updater`

## Requirements
- R1: After reset `busy`, `done` and `cmd_valid` are low and the local configuration copy is invalid, so the next configuration update starts with a read.
- R2: A read descriptor carries opcode 0x0F and the latched register address in `cmd_addr`, and its response data is taken as the old register value.
- R3: The new value is (old & ~mask) | (val & mask): bits outside the mask keep their old state.
- R4: A write descriptor (opcode 0x1F, `cmd_wdata` = new value) is issued only when the new value differs from the old one; otherwise the update ends after the read.
- R5: Updates to address 0xB0 (bit 6 one-time-programmable enable, bit 4 error-correction enable, bit 0 four-line enable) use the local copy once it is valid and issue no read. The copy is loaded from each read response and each acknowledged write to that address. Other addresses are always read from the device.
- R6: A configuration update whose merged value equals the valid local copy completes with no descriptor at all.
- R7: A one-cycle `unlock_req` issues a single write of 0x00 to address 0xA0 with no read before it. When `unlock_req` and `req_valid` are high in the same idle cycle, the unlock is served and the update request is dropped.
- R8: `busy` rises in the cycle after a request is accepted and stays high until completion. Requests and unlock pulses that arrive while `busy` is high are ignored.
- R9: Completion is a one-cycle `done` pulse during which `done_value` shows the register value the device now holds.
- R10: A descriptor stays valid, with opcode, address and write data unchanged, until `cmd_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a masked update (taken when idle) |
| req_addr | input | 8 | Feature register address |
| req_mask | input | 8 | Bits to change |
| req_val | input | 8 | New values for the masked bits |
| unlock_req | input | 1 | Start the clear-all-block-protection write |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_value | output | 8 | Final register value, valid with `done` |
| cmd_valid | output | 1 | Descriptor offered to the sequencer |
| cmd_ready | input | 1 | Sequencer takes the descriptor |
| cmd_op | output | 8 | Descriptor opcode (0x0F read, 0x1F write) |
| cmd_addr | output | 8 | Descriptor register address |
| cmd_wdata | output | 8 | Descriptor write data (zero for reads) |
| rsp_valid | input | 1 | Response for the accepted descriptor |
| rsp_data | input | 8 | Read data carried by the response |

## Verification
The bench runs against a device model that counts read and write descriptors and holds each register's contents. Each configuration update is chosen to separate the cache paths. The first update after reset must read. A repeated identical update must produce no traffic. A changing update must write without reading. An update to a non-configuration address whose merge leaves the value unchanged must read but not write, while a changing one must both read and write. The bench also stalls `cmd_ready`, overlaps a second request and an unlock pulse with a busy operation, and raises unlock and update together. These runs tell apart descriptor holding, refusal while busy and the unlock priority. A reset in mid-run shows that the configuration copy is invalidated.

// File: rtl/feat_reg_pkg.sv
package feat_reg_pkg;
   typedef enum logic [2:0] {
      FR_IDLE,
      FR_GET,
      FR_GET_WAIT,
      FR_EVAL,
      FR_SET,
      FR_SET_WAIT,
      FR_DONE
   } fr_state_t;
endpackage

// File: rtl/feat_merge.sv
module feat_merge #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] old_v,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] val,
   output logic [DATA_W-1:0] merged,
   output logic              differs
);
   always_comb begin
      merged  = (old_v & ~mask) | (val & mask);
      differs = (merged != old_v);
   end
endmodule

// File: rtl/feat_cfg_cache.sv
module feat_cfg_cache #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
      end
   end
endmodule

// File: rtl/feat_reg_updater.sv
module feat_reg_updater #(
   parameter int                 DATA_W     = 8,
   parameter int                 ADDR_W     = 8,
   parameter int                 OP_W       = 8,
   parameter logic [OP_W-1:0]    GET_OP     = 8'h0F,
   parameter logic [OP_W-1:0]    SET_OP     = 8'h1F,
   parameter logic [ADDR_W-1:0]  CFG_ADDR   = 8'hB0,
   parameter logic [ADDR_W-1:0]  LOCK_ADDR  = 8'hA0,
   parameter logic [DATA_W-1:0]  UNLOCK_VAL = 8'h00,
   parameter bit                 CACHE_CFG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_mask,
   input  logic [DATA_W-1:0] req_val,
   input  logic              unlock_req,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] done_value,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [OP_W-1:0]   cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data
);
   import feat_reg_pkg::*;

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   if (DATA_W < 1) begin : g_bad_data_w
      $error("feat_reg_updater: DATA_W must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("feat_reg_updater: ADDR_W must be at least 1");
   end
   if (CFG_ADDR == LOCK_ADDR) begin : g_bad_addr_map
      $error("feat_reg_updater: configuration and lock addresses must differ");
   end
   if (GET_OP == SET_OP) begin : g_bad_ops
      $error("feat_reg_updater: read and write opcodes must differ");
   end

   fr_state_t         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] val_q;
   logic [DATA_W-1:0] old_q;

   logic [DATA_W-1:0] merged;
   logic              differs;
   logic              cache_valid;
   logic [DATA_W-1:0] cache_data;
   logic              cache_load;
   logic [DATA_W-1:0] cache_load_data;
   logic              cache_hit;
   logic              addr_is_cfg;

   feat_merge #(.DATA_W(DATA_W)) u_merge (
      .old_v   (old_q),
      .mask    (mask_q),
      .val     (val_q),
      .merged  (merged),
      .differs (differs)
   );

   assign addr_is_cfg     = (addr_q == CFG_ADDR);
   assign cache_load      = addr_is_cfg && rsp_valid &&
                            (state_q == FR_GET_WAIT || state_q == FR_SET_WAIT);
   assign cache_load_data = (state_q == FR_GET_WAIT) ? rsp_data : merged;

   if (CACHE_CFG) begin : g_cache
      feat_cfg_cache #(.DATA_W(DATA_W)) u_cache (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (cache_load),
         .load_data (cache_load_data),
         .valid     (cache_valid),
         .data      (cache_data)
      );
   end else begin : g_no_cache
      assign cache_valid = 1'b0;
      assign cache_data  = '0;
   end

   assign cache_hit = cache_valid && (req_addr == CFG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FR_IDLE;
         addr_q  <= '0;
         mask_q  <= '0;
         val_q   <= '0;
         old_q   <= '0;
      end else begin
         unique case (state_q)
            FR_IDLE: begin
               if (unlock_req) begin
                  addr_q  <= LOCK_ADDR;
                  mask_q  <= ALL_ONES;
                  val_q   <= UNLOCK_VAL;
                  old_q   <= ~UNLOCK_VAL;
                  state_q <= FR_SET;
               end else if (req_valid) begin
                  addr_q <= req_addr;
                  mask_q <= req_mask;
                  val_q  <= req_val;
                  if (cache_hit) begin
                     old_q   <= cache_data;
                     state_q <= FR_EVAL;
                  end else begin
                     state_q <= FR_GET;
                  end
               end
            end
            FR_GET:      if (cmd_ready) state_q <= FR_GET_WAIT;
            FR_GET_WAIT: if (rsp_valid) begin
               old_q   <= rsp_data;
               state_q <= FR_EVAL;
            end
            FR_EVAL:     state_q <= differs ? FR_SET : FR_DONE;
            FR_SET:      if (cmd_ready) state_q <= FR_SET_WAIT;
            FR_SET_WAIT: if (rsp_valid) state_q <= FR_DONE;
            FR_DONE:     state_q <= FR_IDLE;
            default:     state_q <= FR_IDLE;
         endcase
      end
   end

   always_comb begin
      busy       = (state_q != FR_IDLE);
      done       = (state_q == FR_DONE);
      done_value = merged;
      cmd_valid  = (state_q == FR_GET) || (state_q == FR_SET);
      cmd_op     = (state_q == FR_SET) ? SET_OP : GET_OP;
      cmd_addr   = addr_q;
      cmd_wdata  = (state_q == FR_SET) ? merged : '0;
   end
endmodule

// File: rtl/feat_reg_updater_chk.sv
module feat_reg_updater_chk #(
   parameter int              DATA_W = 8,
   parameter int              ADDR_W = 8,
   parameter int              OP_W   = 8,
   parameter logic [OP_W-1:0] GET_OP = 8'h0F,
   parameter logic [OP_W-1:0] SET_OP = 8'h1F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              unlock_req,
   input logic              busy,
   input logic              done,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [OP_W-1:0]   cmd_op,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [DATA_W-1:0] cmd_wdata
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!cmd_valid && !done));

   a_r2_legal_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_op == GET_OP || cmd_op == SET_OP));

   a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (req_valid || unlock_req)) |=> busy);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_wdata)));
endmodule

bind feat_reg_updater feat_reg_updater_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .OP_W   (OP_W),
   .GET_OP (GET_OP),
   .SET_OP (SET_OP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .unlock_req (unlock_req),
   .busy       (busy),
   .done       (done),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_op     (cmd_op),
   .cmd_addr   (cmd_addr),
   .cmd_wdata  (cmd_wdata)
);

// File: tb/feat_reg_updater_test.sv
`timescale 1ns/1ps
module feat_reg_updater_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_addr = '0, req_mask = '0, req_val = '0;
   logic       unlock_req = 1'b0;
   logic       busy, done, cmd_valid;
   logic [7:0] done_value, cmd_op, cmd_addr, cmd_wdata;
   logic       hold_ready = 1'b0;
   logic       cmd_ready;
   logic       rsp_valid = 1'b0;
   logic [7:0] rsp_data = '0;

   int n_tests = 0, n_fail = 0, cycles = 0;
   int n_get = 0, n_set = 0, n_bad = 0;
   logic [7:0] dev_mem [0:255];
   logic       poke_en = 1'b0;
   logic [7:0] poke_addr = '0, poke_data = '0;
   logic [1:0] pend = '0;
   logic [7:0] pend_data = '0;
   logic [7:0] last_done_value;

   assign cmd_ready = !hold_ready;
   always #10 clk = ~clk;

   feat_reg_updater uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_mask(req_mask), .req_val(req_val), .unlock_req(unlock_req),
      .busy(busy), .done(done), .done_value(done_value),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   // device and sequencer model: response two cycles after acceptance
   always @(posedge clk) begin
      rsp_valid <= 1'b0;
      if (poke_en) dev_mem[poke_addr] <= poke_data;
      if (pend != 0) begin
         pend <= pend - 1;
         if (pend == 1) begin
            rsp_valid <= 1'b1;
            rsp_data  <= pend_data;
         end
      end
      if (cmd_valid && cmd_ready) begin
         pend <= 2;
         if (cmd_op == 8'h0F) begin
            n_get     <= n_get + 1;
            pend_data <= dev_mem[cmd_addr];
         end else if (cmd_op == 8'h1F) begin
            n_set             <= n_set + 1;
            dev_mem[cmd_addr] <= cmd_wdata;
            pend_data         <= 8'h00;
         end else begin
            n_bad <= n_bad + 1;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      poke_en = 1'b1; poke_addr = a; poke_data = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      last_done_value = done_value;
      @(negedge clk);
      check("R9 done lasts one cycle", int'(done), 0);
   endtask

   task automatic run_update(input logic [7:0] a, input logic [7:0] m, input logic [7:0] v);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_mask = m; req_val = v;
      @(negedge clk);
      req_valid = 1'b0;
      check("R8 busy after accept", int'(busy), 1);
      wait_done();
   endtask

   task automatic t_reset_state();
      check("R1 busy low after reset", int'(busy), 0);
      check("R1 cmd_valid low after reset", int'(cmd_valid), 0);
      check("R1 done low after reset", int'(done), 0);
   endtask

   task automatic t_cfg_first();
      int g0 = n_get, s0 = n_set;
      run_update(8'hB0, 8'h40, 8'h40);
      check("R1 R2 first cfg update reads", n_get - g0, 1);
      check("R4 changed value written", n_set - s0, 1);
      check("R3 merged cfg value", int'(dev_mem[8'hB0]), 8'h51);
      check("R9 done_value", int'(last_done_value), 8'h51);
   endtask

   task automatic t_cfg_same();
      int g0 = n_get, s0 = n_set;
      run_update(8'hB0, 8'h40, 8'h40);
      check("R6 no read on cached equal", n_get - g0, 0);
      check("R6 no write on cached equal", n_set - s0, 0);
      check("R6 done_value from copy", int'(last_done_value), 8'h51);
   endtask

   task automatic t_cfg_change();
      int g0 = n_get, s0 = n_set;
      run_update(8'hB0, 8'h11, 8'h01);
      check("R5 cached cfg skips read", n_get - g0, 0);
      check("R5 cached cfg writes", n_set - s0, 1);
      check("R3 cfg bit4 cleared bit0 kept", int'(dev_mem[8'hB0]), 8'h41);
   endtask

   task automatic t_other_nochange();
      int g0 = n_get, s0 = n_set;
      run_update(8'h20, 8'h0F, 8'h0A);
      check("R2 other address read", n_get - g0, 1);
      check("R4 unchanged value not written", n_set - s0, 0);
      check("R4 done_value equals old", int'(last_done_value), 8'h5A);
   endtask

   task automatic t_other_change();
      int g0 = n_get, s0 = n_set;
      run_update(8'h20, 8'hF0, 8'hC3);
      check("R5 other address not cached", n_get - g0, 1);
      check("R4 changed other written", n_set - s0, 1);
      check("R3 merged other value", int'(dev_mem[8'h20]), 8'hCA);
   endtask

   task automatic t_unlock_stall();
      int g0 = n_get, s0 = n_set;
      hold_ready = 1'b1;
      @(negedge clk);
      unlock_req = 1'b1;
      @(negedge clk);
      unlock_req = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R10 descriptor held valid", int'(cmd_valid), 1);
         check("R10 held opcode", int'(cmd_op), 8'h1F);
         check("R10 held address", int'(cmd_addr), 8'hA0);
         check("R10 held data", int'(cmd_wdata), 8'h00);
      end
      hold_ready = 1'b0;
      wait_done();
      check("R7 unlock without read", n_get - g0, 0);
      check("R7 unlock single write", n_set - s0, 1);
      check("R7 lock register cleared", int'(dev_mem[8'hA0]), 8'h00);
   endtask

   task automatic t_busy_refuse();
      int s0 = n_set;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 8'h20; req_mask = 8'hFF; req_val = 8'h11;
      @(negedge clk);
      req_val = 8'h77;
      unlock_req = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; unlock_req = 1'b0;
      wait_done();
      repeat (6) @(negedge clk);
      check("R8 only first request served", int'(dev_mem[8'h20]), 8'h11);
      check("R8 one write while busy", n_set - s0, 1);
      check("R8 lock register untouched", int'(dev_mem[8'hA0]), 8'h33);
      check("R8 idle after refusal", int'(busy), 0);
   endtask

   task automatic t_unlock_priority();
      int g0 = n_get;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 8'h20; req_mask = 8'hFF; req_val = 8'hEE;
      unlock_req = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; unlock_req = 1'b0;
      wait_done();
      repeat (6) @(negedge clk);
      check("R7 unlock wins", int'(dev_mem[8'hA0]), 8'h00);
      check("R7 update dropped", int'(dev_mem[8'h20]), 8'h11);
      check("R7 no read for unlock", n_get - g0, 0);
   endtask

   task automatic t_reset_invalidates();
      int g0, s0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      g0 = n_get; s0 = n_set;
      run_update(8'hB0, 8'h40, 8'h40);
      check("R1 copy invalid after reset", n_get - g0, 1);
      check("R4 no write when device matches", n_set - s0, 0);
      check("R9 done_value from device", int'(last_done_value), 8'h41);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      poke(8'hB0, 8'h11);
      poke(8'hA0, 8'h38);
      poke(8'h20, 8'h5A);
      t_reset_state();
      t_cfg_first();
      t_cfg_same();
      t_cfg_change();
      t_other_nochange();
      t_other_change();
      t_unlock_stall();
      poke(8'hA0, 8'h33);
      t_busy_refuse();
      t_unlock_priority();
      t_reset_invalidates();
      check("R2 only read and write opcodes seen", n_bad, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule